// File: doc/BRIEF.md
# Prescaled Per-Core Countdown Timer

A 32-bit down-counter with a programmable clock divider, reached through a small word-addressed register port. Software sets a reload value, a starting count and a control word that holds the enable, the auto-reload choice and an 8-bit divide ratio. While the timer is enabled and its count is nonzero, the count drops by one every (divide + 1) clock cycles.

When the count runs out, a sticky status flag is set. In one-shot mode the counter then stays at zero and stops. In auto-reload mode it starts again from the reload value. The interrupt output gives a single-cycle pulse only when the status flag goes from clear to set. Software clears the flag by writing a one to it.

Top module: `core_tmr`

## Requirements
- R1: After reset, every register reads as zero and irq_o is low.
- R2: Word index 0 is the reload value, index 1 is the counter, index 2 is control and index 3 is status. Indices 4 to 7 read as zero, and writes to them have no effect. Control reads back only bit 0 (enable), bit 1 (auto-reload) and bits 15:8 (divide ratio). Every other control bit reads as zero.
- R3: A write to index 0 stores the value as the reload value and also places it in the counter. A write to index 1 changes only the counter. A write to index 0, 1 or 2 restarts the divider.
- R4: While the timer is enabled and the count is nonzero, the count drops by one every (divide + 1) cycles. A cycle that carries a write to index 0 to 3 neither advances the divider nor decrements the count.
- R5: Index 1 reads as zero while the timer is disabled. The held count is kept and reappears when the timer is enabled again.
- R6: When a decrement takes the count from 1 to 0, status bit 0 is set. With auto-reload on, the counter takes the reload value. Otherwise it stays at zero and counting stops.
- R7: A control write that turns enable from 0 to 1, with auto-reload set and the count at zero, first copies the reload value into the counter.
- R8: A write to index 3 clears status bit 0 when bit 0 of the written data is 1. Written with 0, the bit is left unchanged.
- R9: irq_o is high for exactly one cycle, in the first cycle in which status reads 1 after being 0. An expiry while status is already set produces no pulse.
- R10: A count of zero never produces an expiry, even while the timer is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the word at addr_i |
| addr_i | input | 3 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word at addr_i (combinational) |
| irq_o | output | 1 | Single-cycle pulse when status rises |

## Verification
A divider that slips by one cycle appears on the counter readback no later than the second decrement. It also moves the expiry edge, so both the status flag and irq_o land in the wrong cycle. A reload path that loads the wrong value breaks the period of the next auto-reload cycle, which the bench sees within one period. A status flag that is wrongly cleared or wrongly set shows up the same cycle, either as an extra interrupt pulse or as a missing one. A reference model runs in lockstep with the design and compares readback and irq_o after every clock edge, so a fault is reported in the cycle it first becomes visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 32;
  localparam int PRE_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int EN_BIT  = 0;
  localparam int AR_BIT  = 1;
  localparam int PRE_LSB = 8;

  typedef enum logic [1:0] {
    IDX_LOAD = 2'd0,
    IDX_CNT  = 2'd1,
    IDX_CTRL = 2'd2,
    IDX_STAT = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic [PRE_W-1:0] div;
    logic             ar;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;

  assign tick_o = run_i && !hold_i && (pre_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (clr_i)          pre_q <= '0;
    else if (hold_i)         pre_q <= pre_q;
    else if (tick_o)         pre_q <= '0;
    else if (run_i)          pre_q <= pre_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> pre_q == '0); // R3

  AST_PRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold_i) && !$past(clr_i)) |-> $stable(pre_q)); // R4
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             set_i,
  input  logic [CNT_W-1:0] set_val_i,
  input  logic             ar_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // expiry only from a count of one; zero never ticks
  assign expire_o = tick_i && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (set_i)       cnt_q <= set_val_i;
    else if (expire_o)    cnt_q <= ar_i ? reload_i : '0;
    else if (tick_i)      cnt_q <= cnt_q - 1'b1;
  end

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !set_i && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1); // R4

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !set_i && !ar_i) |=> cnt_q == '0); // R6

  AST_ZERO_NO_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !expire_o); // R10
endmodule

// File: rtl/core_tmr.sv
module core_tmr
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int NREG = 4;

  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             stat_q;
  logic             irq_q;

  logic             mapped;
  logic [NREG-1:0]  wsel;
  logic             any_wr, clr_pre, en_rise;
  logic             cnt_set;
  logic [CNT_W-1:0] cnt_set_val;
  logic [CNT_W-1:0] cnt;
  logic             tick, expire;
  ctrl_t            ctrl_wd;

  assign mapped = (addr_i < ADDR_W'(NREG));

  for (genvar g = 0; g < NREG; g++) begin : g_wsel
    assign wsel[g] = wr_en_i && mapped && (addr_i[1:0] == 2'(g));
  end

  assign ctrl_wd = '{div: wdata_i[PRE_LSB +: PRE_W], ar: wdata_i[AR_BIT], en: wdata_i[EN_BIT]};
  assign any_wr  = |wsel;
  assign clr_pre = wsel[IDX_LOAD] | wsel[IDX_CNT] | wsel[IDX_CTRL];
  assign en_rise = wsel[IDX_CTRL] && !ctrl_q.en && ctrl_wd.en;

  always_comb begin
    cnt_set     = 1'b0;
    cnt_set_val = wdata_i;
    if (wsel[IDX_LOAD] || wsel[IDX_CNT]) begin
      cnt_set = 1'b1;
    end else if (en_rise && ctrl_wd.ar && cnt == '0) begin
      cnt_set     = 1'b1;
      cnt_set_val = load_q;
    end
  end

  tmr_presc #(.PRE_W(PRE_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.en && cnt != '0),
    .hold_i (any_wr),
    .clr_i  (clr_pre),
    .div_i  (ctrl_q.div),
    .tick_o (tick)
  );

  tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .set_i     (cnt_set),
    .set_val_i (cnt_set_val),
    .ar_i      (ctrl_q.ar),
    .reload_i  (load_q),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      ctrl_q <= '0;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wsel[IDX_LOAD]) load_q <= wdata_i;
      if (wsel[IDX_CTRL]) ctrl_q <= ctrl_wd;
      if (expire)                                stat_q <= 1'b1;
      else if (wsel[IDX_STAT] && wdata_i[0])     stat_q <= 1'b0;
      irq_q <= expire && !stat_q;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (mapped) begin
      unique case (reg_idx_e'(addr_i[1:0]))
        IDX_LOAD: rdata_o = load_q;
        IDX_CNT:  rdata_o = ctrl_q.en ? cnt : '0;
        IDX_CTRL: begin
          rdata_o[EN_BIT]              = ctrl_q.en;
          rdata_o[AR_BIT]              = ctrl_q.ar;
          rdata_o[PRE_LSB +: PRE_W]    = ctrl_q.div;
        end
        IDX_STAT: rdata_o[0] = stat_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R9

  AST_IRQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_q && !$past(stat_q))); // R9

  AST_STAT_RISE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> irq_o); // R6

  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsel[IDX_STAT] && wdata_i[0] && !expire) |=> !stat_q); // R8
endmodule

// File: tb/tb_core_tmr.sv
module tb_core_tmr;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [W-1:0]  wd = '0;
  logic [W-1:0]  rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [W-1:0] m_load, m_cnt;
  logic         m_en, m_ar, m_stat, m_irq;
  logic [7:0]   m_div, m_pre;

  always #4 clk = ~clk;

  core_tmr dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [W-1:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_load;
      3'd1: return m_en ? m_cnt : '0;
      3'd2: return {16'h0, m_div, 6'h0, m_ar, m_en};
      3'd3: return {31'h0, m_stat};
      default: return '0;
    endcase
  endfunction

  task automatic m_step(input logic w, input logic [2:0] a, input logic [W-1:0] d);
    logic any_w, clr, tick, exp_now;
    logic [W-1:0] n_cnt;
    logic [7:0] n_pre;
    logic n_stat;
    any_w   = w && a < 3'd4;
    clr     = w && a < 3'd3;
    tick    = m_en && m_cnt != 0 && !any_w && m_pre == m_div;
    exp_now = tick && m_cnt == 1;
    n_cnt = m_cnt;
    if (w && (a == 3'd0 || a == 3'd1)) n_cnt = d;
    else if (w && a == 3'd2 && !m_en && d[0] && d[1] && m_cnt == 0) n_cnt = m_load;
    else if (exp_now) n_cnt = m_ar ? m_load : '0;
    else if (tick) n_cnt = m_cnt - 1;
    n_pre = m_pre;
    if (clr) n_pre = 0;
    else if (any_w) n_pre = m_pre;
    else if (tick) n_pre = 0;
    else if (m_en && m_cnt != 0) n_pre = m_pre + 1;
    n_stat = exp_now ? 1'b1 : (w && a == 3'd3 && d[0]) ? 1'b0 : m_stat;
    m_irq = exp_now && !m_stat;
    m_stat = n_stat;
    m_cnt = n_cnt;
    m_pre = n_pre;
    if (w && a == 3'd0) m_load = d;
    if (w && a == 3'd2) begin m_en = d[0]; m_ar = d[1]; m_div = d[15:8]; end
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R3 load";
      3'd1: return "R5 counter";
      3'd2: return "R2 control";
      3'd3: return "R6 status";
      default: return "R2 unmapped";
    endcase
  endfunction

  // one clock: drive, step model, compare after the edge
  task automatic cyc(input logic w, input logic [2:0] a, input logic [W-1:0] d,
                     input logic [2:0] ra);
    @(negedge clk);
    we = w; addr = a; wd = d;
    m_step(w, a, d);
    @(posedge clk);
    #1;
    we = 1'b0; addr = ra;
    #1;
    chk(tag_of(ra), rdata, m_read(ra));
    chk("R9 irq", {31'h0, irq}, {31'h0, m_irq});
  endtask

  task automatic idle(input int n, input logic [2:0] ra);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, '0, ra);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_load = 0; m_cnt = 0; m_en = 0; m_ar = 0; m_stat = 0; m_irq = 0; m_div = 0; m_pre = 0;
    #20 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1 reset read", rdata, '0);
    end
    chk("R1 reset irq", {31'h0, irq}, '0);

    // R2 control mask, unmapped ignored
    cyc(1'b1, 3'd2, 32'hFFFF_FFFC, 3'd2);
    chk("R2 ctrl mask", rdata, 32'h0000_FF00);
    cyc(1'b1, 3'd5, 32'h1234_5678, 3'd5);
    chk("R2 unmapped", rdata, '0);
    cyc(1'b1, 3'd2, 32'h0, 3'd0);
    chk("R2 unmapped write no effect", rdata, '0);

    // R3 load write mirrors into counter; counter write leaves load
    cyc(1'b1, 3'd0, 32'd7, 3'd0);
    chk("R3 load", rdata, 32'd7);
    cyc(1'b1, 3'd1, 32'd3, 3'd0);
    chk("R3 load kept", rdata, 32'd7);
    // R5 disabled counter reads zero
    cyc(1'b0, 3'd0, '0, 3'd1);
    chk("R5 disabled reads zero", rdata, '0);

    // R4/R6 one-shot, divide 1 -> 2 cycles per step, count 3
    cyc(1'b1, 3'd2, 32'h0000_0101, 3'd1);
    chk("R5 held count visible", rdata, 32'd3);
    idle(5, 3'd1);
    chk("R4 count after 5 cycles", rdata, 32'd1);
    idle(1, 3'd3);
    chk("R6 status set", rdata, 32'd1);
    chk("R9 irq pulse", {31'h0, irq}, 32'd1);
    idle(1, 3'd1);
    chk("R6 one-shot stays zero", rdata, '0);
    chk("R9 single cycle", {31'h0, irq}, '0);
    idle(10, 3'd3);
    chk("R10 no expiry at zero", {31'h0, irq}, '0);

    // R8 write 0 keeps, write 1 clears
    cyc(1'b1, 3'd3, 32'hFFFF_FFFE, 3'd3);
    chk("R8 zero write keeps", rdata, 32'd1);
    cyc(1'b1, 3'd3, 32'h1, 3'd3);
    chk("R8 clear", rdata, '0);

    // R7 enable edge with zero count and auto-reload pulls load (7)
    cyc(1'b1, 3'd2, 32'h0, 3'd1);
    cyc(1'b1, 3'd2, 32'h0000_0003, 3'd1);
    chk("R7 count from load", rdata, 32'd7);
    idle(7, 3'd1);
    chk("R6 auto-reload restart", rdata, 32'd7);
    chk("R9 irq on reload expiry", {31'h0, irq}, 32'd1);
    idle(7, 3'd1);
    chk("R9 no pulse while status set", {31'h0, irq}, '0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [2:0] a, ra;
      logic [W-1:0] d;
      w  = ($urandom % 8) == 0;
      a  = 3'($urandom % 8);
      ra = 3'($urandom % 8);
      d  = $urandom;
      if (a == 3'd0 || a == 3'd1) d = $urandom % 24;
      if (a == 3'd2) d[15:10] = '0;
      cyc(w, a, d, ra);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule